// File: doc/BRIEF.md
# Trace Register Access Port over JTAG

This block lets a debug host reach the control and data registers of an on-chip trace buffer through the test access port. It works with an external TAP state machine, which supplies the usual capture, shift and update strobes for the instruction and data paths. The block keeps its own 4-bit instruction register and a small chain-select register. One instruction selects a 40-bit access chain. Each completed scan of that chain becomes a single read or write on a simple internal register bus.

The access chain is shifted least significant bit first. Bits 31:0 hold the data word, bits 38:32 hold the register address and bit 39 is the direction flag. A write is carried out when the scan's Update-DR arrives. A read scan only posts the address. The value it fetches appears in the data field when the following scan is captured. Reading the trace RAM data port removes one entry from the RAM. For this reason, a host that drains the RAM ends with a read of address 0. Address 0 is served inside the block with a fixed identification word and causes no bus access. The last RAM word can then be collected without fetching an extra entry.

Top module: `trp_jtag_port`

## Requirements
- R1: After trst_n is asserted, the instruction register holds all ones (bypass), the chain-select register holds all ones, reg_rd and reg_wr are low, and the held read value is zero.
- R2: An instruction scan captures the pattern 4'b0001 and shifts it out LSB first. The shifted code takes effect only on Update-IR. Code 4'hC selects the access path, code 4'h2 selects the chain-select register, and every other code selects bypass.
- R3: With code 4'h2 in force, the data path is the 4-bit chain-select register. Capture-DR loads its current value, and the shifted value is latched on Update-DR.
- R4: The 40-bit access chain is in the data path only when the instruction is 4'hC and the chain number is 0. In every other case the data path is a 1-bit bypass stage, which captures 0 and delays TDI by one shift.
- R5: The access chain is shifted LSB first, with data in bits 31:0, address in bits 38:32 and the direction flag in bit 39 (1 = write, 0 = read).
- R6: A write scan to a nonzero address drives reg_wr high for exactly the one cycle after Update-DR. During that cycle reg_addr and reg_wdata carry the scanned address and data.
- R7: A read scan to a nonzero address drives reg_rd high for the one cycle after Update-DR, with reg_addr set to the scanned address. reg_rdata is taken in that cycle. The next Capture-DR loads it into bits 31:0 and loads zeros into bits 39:32.
- R8: A read of address 0 causes no bus strobe, and the next scan returns the identification constant 32'h1B7E0A01. A write to address 0 causes no bus strobe.
- R9: Each Update-DR of the access chain gives at most one bus strobe. An Update-DR while the access chain is not selected gives none.
- R10: reg_rd and reg_wr are never high together, and each stays high for only one cycle.
- R11: The held read value stays unchanged until the next read, so later captures return it again. Successive reads of RAM address 4 each take exactly one entry, in order, and a closing read of address 0 returns the last entry without taking another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out from the selected register |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 32 | Register bus write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 32 | Read data, valid while reg_rd is high |

## Verification
The assertions assume that the TAP strobes are mutually exclusive and follow the legal state order. In particular, two Update-DR pulses are never back to back, and at least one idle cycle separates an Update-DR from the next Capture-DR. They also assume that reg_rdata answers in the same cycle as reg_rd. The bench drives the strobes only through its instruction-scan and data-scan tasks. These tasks keep idle cycles after every update. The bench's register model answers combinationally. Random addresses leave out 0 and the RAM port, so those two are covered by directed sequences only.

// File: rtl/trp_pkg.sv
package trp_pkg;
    typedef enum logic [1:0] {
        DR_BYPASS  = 2'd0,
        DR_CHAINSEL = 2'd1,
        DR_ACCESS  = 2'd2
    } dr_sel_e;
endpackage

// File: rtl/trp_instr.sv
module trp_instr
    import trp_pkg::*;
#(
    parameter int IR_W = 4,
    parameter int CHAIN_W = 4,
    parameter logic [IR_W-1:0] ACCESS_CODE = 4'hC,
    parameter logic [IR_W-1:0] SELECT_CODE = 4'h2
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               capture_ir,
    input  logic               shift_ir,
    input  logic               update_ir,
    input  logic [CHAIN_W-1:0] chain_num,
    output logic               ir_tdo,
    output dr_sel_e            dr_sel
);
    localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0] shreg;
        logic [IR_W-1:0] code;
    } ir_state_t;

    ir_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (capture_ir) begin
            s_d.shreg = CAPTURE_PAT;
        end else if (shift_ir) begin
            s_d.shreg = {tdi, s_q.shreg[IR_W-1:1]};
        end else if (update_ir) begin
            s_d.code = s_q.shreg;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            s_q.shreg <= '0;
            s_q.code  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (s_q.code == ACCESS_CODE && chain_num == '0) begin
            dr_sel = DR_ACCESS;
        end else if (s_q.code == SELECT_CODE) begin
            dr_sel = DR_CHAINSEL;
        end else begin
            dr_sel = DR_BYPASS;
        end
    end

    assign ir_tdo = s_q.shreg[0];
endmodule

// File: rtl/trp_chainsel.sv
module trp_chainsel #(
    parameter int CHAIN_W = 4
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    output logic               cs_tdo,
    output logic [CHAIN_W-1:0] chain_num
);
    typedef struct packed {
        logic [CHAIN_W-1:0] shreg;
        logic [CHAIN_W-1:0] chain;
    } cs_state_t;

    cs_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sel) begin
            if (capture_dr) begin
                s_d.shreg = s_q.chain;
            end else if (shift_dr) begin
                s_d.shreg = {tdi, s_q.shreg[CHAIN_W-1:1]};
            end else if (update_dr) begin
                s_d.chain = s_q.shreg;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            s_q.shreg <= '0;
            s_q.chain <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_tdo    = s_q.shreg[0];
    assign chain_num = s_q.chain;
endmodule

// File: rtl/trp_access.sv
module trp_access #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    parameter logic [DATA_W-1:0] ID_CODE = 32'h1B7E_0A01
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              acc_tdo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    output logic              reg_wr
);
    localparam int CHAIN_LEN = DATA_W + ADDR_W + 1;
    localparam int FLAG_BIT  = CHAIN_LEN - 1;

    typedef struct packed {
        logic [CHAIN_LEN-1:0] shreg;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic [DATA_W-1:0]    hold;
        logic                 rd;
        logic                 wr;
    } acc_state_t;

    acc_state_t s_d, s_q;
    logic [ADDR_W-1:0] scan_addr;
    logic [DATA_W-1:0] fresh;

    assign scan_addr = s_q.shreg[DATA_W +: ADDR_W];
    assign fresh     = s_q.rd ? reg_rdata : s_q.hold;

    always_comb begin
        s_d    = s_q;
        s_d.rd = 1'b0;
        s_d.wr = 1'b0;
        s_d.hold = fresh;
        if (sel) begin
            if (capture_dr) begin
                s_d.shreg = {{(ADDR_W + 1){1'b0}}, fresh};
            end else if (shift_dr) begin
                s_d.shreg = {tdi, s_q.shreg[CHAIN_LEN-1:1]};
            end else if (update_dr) begin
                s_d.addr = scan_addr;
                if (s_q.shreg[FLAG_BIT]) begin
                    if (scan_addr != '0) begin
                        s_d.wr    = 1'b1;
                        s_d.wdata = s_q.shreg[DATA_W-1:0];
                    end
                end else if (scan_addr == '0) begin
                    s_d.hold = ID_CODE;
                end else begin
                    s_d.rd = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_tdo   = s_q.shreg[0];
    assign reg_addr  = s_q.addr;
    assign reg_wdata = s_q.wdata;
    assign reg_rd    = s_q.rd;
    assign reg_wr    = s_q.wr;
endmodule

// File: rtl/trp_jtag_port.sv
module trp_jtag_port
    import trp_pkg::*;
#(
    parameter int IR_W = 4,
    parameter int CHAIN_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7,
    parameter logic [IR_W-1:0] ACCESS_CODE = 4'hC,
    parameter logic [IR_W-1:0] SELECT_CODE = 4'h2,
    parameter logic [DATA_W-1:0] ID_CODE = 32'h1B7E_0A01
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    output logic              tdo,
    input  logic              capture_ir,
    input  logic              shift_ir,
    input  logic              update_ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    output logic              reg_wr,
    input  logic [DATA_W-1:0] reg_rdata
);
    dr_sel_e            dr_sel;
    logic [CHAIN_W-1:0] chain_num;
    logic               ir_tdo, cs_tdo, acc_tdo;
    logic               byp_d, byp_q;

    trp_instr #(
        .IR_W(IR_W), .CHAIN_W(CHAIN_W),
        .ACCESS_CODE(ACCESS_CODE), .SELECT_CODE(SELECT_CODE)
    ) u_instr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .chain_num(chain_num), .ir_tdo(ir_tdo), .dr_sel(dr_sel)
    );

    trp_chainsel #(.CHAIN_W(CHAIN_W)) u_chainsel (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .sel(dr_sel == DR_CHAINSEL),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .cs_tdo(cs_tdo), .chain_num(chain_num)
    );

    trp_access #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_CODE(ID_CODE)) u_access (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .sel(dr_sel == DR_ACCESS),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .reg_rdata(reg_rdata), .acc_tdo(acc_tdo),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr)
    );

    always_comb begin
        byp_d = byp_q;
        if (dr_sel == DR_BYPASS) begin
            if (capture_dr) begin
                byp_d = 1'b0;
            end else if (shift_dr) begin
                byp_d = tdi;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else begin
            byp_q <= byp_d;
        end
    end

    always_comb begin
        if (shift_ir) begin
            tdo = ir_tdo;
        end else begin
            case (dr_sel)
                DR_ACCESS:   tdo = acc_tdo;
                DR_CHAINSEL: tdo = cs_tdo;
                default:     tdo = byp_q;
            endcase
        end
    end
endmodule

// File: rtl/trp_jtag_port_chk.sv
module trp_jtag_port_chk
    import trp_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              tck,
    input logic              trst_n,
    input logic              update_dr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input dr_sel_e           dr_sel
);
    AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
        !(reg_rd && reg_wr)); // R10
    AST_RD_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
        reg_rd |=> !reg_rd); // R10
    AST_WR_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
        reg_wr |=> !reg_wr); // R10
    AST_STROBE_FROM_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (reg_rd || reg_wr) |-> ($past(update_dr) && $past(dr_sel == DR_ACCESS))); // R9
    AST_NO_ADDR0_STROBE: assert property (@(posedge tck) disable iff (!trst_n)
        (reg_rd || reg_wr) |-> (reg_addr != '0)); // R8
endmodule

bind trp_jtag_port trp_jtag_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .tck(tck), .trst_n(trst_n), .update_dr(update_dr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .dr_sel(dr_sel)
);

// File: tb/test_trp_jtag_port.sv
module test_trp_jtag_port;
    localparam logic [31:0] ID_WORD = 32'h1B7E_0A01;
    localparam logic [6:0]  RAM_ADDR = 7'd4;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0;
    logic tdo;
    logic capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic reg_rd, reg_wr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] dev_regs [128];
    logic [31:0] exp_regs [128];
    int pops = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [6:0]  last_addr;
    logic [31:0] last_wdata;

    always #2 tck = ~tck;

    trp_jtag_port i_trp_jtag_port (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] ram_word(int n);
        return 32'hC0DE_0000 + 32'(n) * 32'd3;
    endfunction

    assign reg_rdata = (reg_addr == RAM_ADDR) ? ram_word(pops) : dev_regs[reg_addr];

    always @(posedge tck) begin
        if (reg_rd) begin
            rd_cnt <= rd_cnt + 1;
            last_addr <= reg_addr;
            if (reg_addr == RAM_ADDR) pops <= pops + 1;
        end
        if (reg_wr) begin
            wr_cnt <= wr_cnt + 1;
            last_addr <= reg_addr;
            last_wdata <= reg_wdata;
            dev_regs[reg_addr] <= reg_wdata;
        end
    end

    function automatic logic [39:0] frame(logic wr, logic [6:0] a, logic [31:0] d);
        return {wr, a, d};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
        @(negedge tck) capture_ir = 1'b1;
        @(negedge tck) capture_ir = 1'b0;
        shift_ir = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tdi = code[i];
            #1 cap[i] = tdo;
            @(negedge tck);
        end
        shift_ir = 1'b0;
        update_ir = 1'b1;
        @(negedge tck) update_ir = 1'b0;
        @(negedge tck);
    endtask

    task automatic dr_scan(input int n, input logic [39:0] din, output logic [39:0] dout);
        dout = '0;
        @(negedge tck) capture_dr = 1'b1;
        @(negedge tck) capture_dr = 1'b0;
        shift_dr = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi = din[i];
            #1 dout[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        @(negedge tck) update_dr = 1'b0;
        @(negedge tck);
        @(negedge tck);
    endtask

    task automatic select_chain(input logic [3:0] c, output logic [3:0] old);
        logic [3:0] cap;
        logic [39:0] o;
        ir_scan(4'h2, cap);
        dr_scan(4, {36'd0, c}, o);
        old = o[3:0];
        ir_scan(4'hC, cap);
    endtask

    initial begin
        logic [3:0] cap, old;
        logic [39:0] o, pat;
        int r0, w0;
        void'($urandom(32'd5150));
        for (int i = 0; i < 128; i++) begin
            dev_regs[i] = '0;
            exp_regs[i] = '0;
        end
        repeat (3) @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);
        // R1: quiet bus after reset
        check("R1 strobes", {reg_rd, reg_wr}, 2'b00);
        // R1 R4: bypass after reset
        pat = 40'h00_0000_00B5;
        dr_scan(8, pat, o);
        check("R4 bypass", o[7:0], {pat[6:0], 1'b0});
        // R2: capture pattern
        ir_scan(4'h2, cap);
        check("R2 ir capture", cap, 4'b0001);
        // R3: chain select capture shows reset value
        dr_scan(4, 40'd0, o);
        check("R3 chain capture", o[3:0], 4'hF);
        ir_scan(4'hC, cap);
        // R1: first access capture holds zero
        dr_scan(40, 40'd0, o);
        check("R1 hold zero", o, 40'd0);
        // R6 R5: write
        r0 = rd_cnt; w0 = wr_cnt;
        dr_scan(40, frame(1'b1, 7'd5, 32'hDEAD_BEEF), o);
        exp_regs[5] = 32'hDEAD_BEEF;
        check("R6 wr count", wr_cnt - w0, 1);
        check("R9 rd count", rd_cnt - r0, 0);
        check("R6 wr addr", last_addr, 7'd5);
        check("R5 wr data", last_wdata, 32'hDEAD_BEEF);
        // R7: read posted, returns in next scan
        dr_scan(40, frame(1'b0, 7'd5, 32'h0), o);
        check("R7 rd count", rd_cnt - r0, 1);
        r0 = rd_cnt;
        dr_scan(40, frame(1'b0, 7'd0, 32'h0), o);
        check("R7 read data", o, {8'd0, 32'hDEAD_BEEF});
        check("R8 no strobe addr0", rd_cnt - r0, 0);
        // R11: held value seen again after a write
        w0 = wr_cnt;
        dr_scan(40, frame(1'b1, 7'd0, 32'h1234_5678), o);
        check("R8 id word", o[31:0], ID_WORD);
        check("R8 addr0 write ignored", wr_cnt - w0, 0);
        dr_scan(40, frame(1'b1, 7'd9, 32'h0000_0099), o);
        exp_regs[9] = 32'h99;
        check("R11 held value", o[31:0], ID_WORD);
        // R11: RAM drain with flush
        pops = 0;
        dr_scan(40, frame(1'b0, RAM_ADDR, 32'h0), o);
        for (int k = 0; k < 3; k++) begin
            dr_scan(40, frame(1'b0, (k == 2) ? 7'd0 : RAM_ADDR, 32'h0), o);
            check("R11 ram entry", o[31:0], ram_word(k));
        end
        check("R11 ram pops", pops, 3);
        // R4 R9: chain 1 gives bypass and no strobes
        select_chain(4'd1, old);
        check("R3 chain old", old, 4'd0);
        r0 = rd_cnt; w0 = wr_cnt;
        pat = frame(1'b1, 7'd7, 32'hA5A5_0F0F);
        dr_scan(40, pat, o);
        check("R4 bypass chain1", o, {pat[38:0], 1'b0});
        check("R9 no strobe chain1", (rd_cnt - r0) + (wr_cnt - w0), 0);
        select_chain(4'd0, old);
        check("R3 chain latched", old, 4'd1);
        // R2: unknown code is bypass
        ir_scan(4'h5, cap);
        dr_scan(4, 40'hA, o);
        check("R2 other code bypass", o[3:0], 4'b0100);
        ir_scan(4'hC, cap);
        // random traffic
        for (int it = 0; it < 60; it++) begin
            logic [6:0] a;
            logic [31:0] d;
            a = 7'($urandom_range(1, 127));
            if (a == RAM_ADDR) a = 7'd6;
            d = $urandom;
            if ($urandom_range(0, 1) == 1) begin
                w0 = wr_cnt;
                dr_scan(40, frame(1'b1, a, d), o);
                exp_regs[a] = d;
                check("R6 random write", {wr_cnt - w0, last_addr, last_wdata}, {32'd1, a, d});
            end else begin
                dr_scan(40, frame(1'b0, a, 32'h0), o);
                dr_scan(40, frame(1'b0, 7'd0, 32'h0), o);
                check("R7 random read", o[31:0], exp_regs[a]);
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule